// File: doc/BRIEF.md
# Three-Edge Parallel ADC Read Sequencer

This block sits on the host side of a byte-wide parallel successive-approximation converter. The converter is driven by counting chip-select falling edges, and the read/convert level at each edge means something different. The sequencer produces all of these edges itself. At the first falling edge, with read/convert low, acquisition begins. At the second falling edge, the read/convert level picks standby (reference kept on) or shutdown (reference powered down after conversion). The third falling edge comes only after the end-of-conversion line has dropped. At that edge read/convert is high, and the upper and then the lower byte are read with a high-byte select line. The two bytes are joined into a 14-bit sample.

All timing is counted in clock cycles and set by parameters: chip-select low and high widths, data-valid delay, acquisition length, reference settling after a shutdown cycle, bus relinquish gap, minimum start-to-start period and an end-of-conversion timeout. The sequencer remembers whether the last completed conversion chose shutdown. It stretches the acquisition phase to the settling time only in that case, and also after reset or a timeout, because the converter state is then unknown.

The finished sample leaves on a valid/ready stream. The sample is held, unchanged, until the consumer takes it. While a sample waits, no new conversion is begun, so back-pressure stalls the converter and no data is lost. A start pulse is acted on only when `busy` is low; otherwise it is dropped. Bipolar configurations also present the result in two's-complement form.

Top module: `adc_host_seq`

## Requirements
- R1: After reset, `adc_cs_n` is 1, `adc_rc` is 0, `adc_hben` is 0, `sample_valid` is 0, `err_timeout` is 0 and `busy` is 0.
- R2: A `start` pulse begins a conversion cycle only when `busy` is low. `busy` is high while a cycle runs, while a sample waits unaccepted, or while the pacing gaps of R8 have not elapsed. A `start` given while `busy` is high produces no chip-select falling edge.
- R3: The first chip-select fall of a cycle has `adc_rc` at 0. `adc_rc` changes only on cycles in which `adc_cs_n` is 1.
- R4: At the second chip-select fall, `adc_rc` equals the `shutdown_sel` value captured with the accepted `start` (1 = shutdown, 0 = standby).
- R5: Every chip-select low pulse lasts at least CS_LOW_CYC cycles, and every high pulse at least CS_HIGH_CYC cycles.
- R6: The third chip-select fall, with `adc_rc` at 1, happens only after `adc_eoc_n` has been seen low. During the read, `adc_hben` is 1 first and then 0, and each byte is captured at least DATA_DLY_CYC cycles after the chip-select fall or after the `adc_hben` change. `sample_data` = {upper byte bits 5..0, lower byte}, and bus bits 7..6 of the upper byte are zero.
- R7: If the previous completed conversion chose shutdown, or the cycle is the first after reset or after a timeout, the first and second chip-select falls are at least SETTLE_CYC cycles apart. Otherwise they are exactly CS_LOW_CYC + max(CS_HIGH_CYC, ACQ_CYC) cycles apart.
- R8: The first chip-select fall of a cycle comes at least max(RELINQ_CYC, CS_HIGH_CYC) cycles after the preceding chip-select rise. First falls of successive cycles are at least PERIOD_CYC cycles apart.
- R9: `sample_valid` stays high with `sample_data` and `sample_signed` unchanged until a cycle with `sample_ready` high, and drops on the next cycle after that handshake.
- R10: With BIPOLAR=1, `sample_signed` equals `sample_data` with bit 13 inverted (offset binary to two's complement). With BIPOLAR=0, it equals `sample_data`.
- R11: If `adc_eoc_n` is not seen low within TIMEOUT_CYC cycles after the second fall, `err_timeout` goes high. Chip-select stays high, no sample is produced and the sequencer returns to idle. `err_timeout` clears when the next `start` is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request one conversion cycle (pulse) |
| shutdown_sel | input | 1 | Power mode for this cycle: 1 shutdown, 0 standby |
| busy | output | 1 | High when a start would be dropped |
| err_timeout | output | 1 | End-of-conversion wait expired |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_rc | output | 1 | Converter read/convert level |
| adc_hben | output | 1 | Byte select: 1 upper, 0 lower |
| adc_eoc_n | input | 1 | Converter end of conversion, low when done |
| adc_data | input | 8 | Converter data bus |
| sample_valid | output | 1 | Sample stream valid |
| sample_ready | input | 1 | Sample stream ready |
| sample_data | output | 14 | Assembled result as read |
| sample_signed | output | 14 | Two's-complement form of the result |

## Verification
A converter model in the bench answers the chip-select edges and times its own end-of-conversion. It is driven with a sweep of result codes: both extremes, both sides of mid-scale, walking ones, walking zeros and a strided spread. A byte swap, a misplaced bit or a wrong sign-bit flip each show up on a different code. Power modes alternate in an irregular pattern, so the measured acquisition span tells apart a cycle that needs settling from one that does not. Separate runs hold ready low while starts are pulsed, fire a second start mid-cycle, and withhold end-of-conversion to force the timeout and the settling that must follow it.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;

  localparam int RES_W = 14;
  localparam int BUS_W = 8;
  localparam int HI_W  = RES_W - BUS_W;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ACQ_LO,
    S_ACQ_HI,
    S_CNV_LO,
    S_CNV_HI,
    S_RD_HI,
    S_RD_LO
  } seq_state_t;

  typedef struct packed {
    logic cs_n;
    logic rc;
    logic hben;
  } pins_t;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Pin levels held during each sequencer state.
  function automatic pins_t pin_decode(input seq_state_t st, input logic shdn);
    pins_t p;
    p = '{cs_n: 1'b1, rc: 1'b0, hben: 1'b0};
    case (st)
      S_ACQ_LO: p = '{cs_n: 1'b0, rc: 1'b0, hben: 1'b0};
      S_ACQ_HI: p = '{cs_n: 1'b1, rc: shdn, hben: 1'b0};
      S_CNV_LO: p = '{cs_n: 1'b0, rc: shdn, hben: 1'b0};
      S_CNV_HI: p = '{cs_n: 1'b1, rc: 1'b1, hben: 1'b0};
      S_RD_HI:  p = '{cs_n: 1'b0, rc: 1'b1, hben: 1'b1};
      S_RD_LO:  p = '{cs_n: 1'b0, rc: 1'b1, hben: 1'b0};
      default:  p = '{cs_n: 1'b1, rc: 1'b0, hben: 1'b0};
    endcase
    return p;
  endfunction

endpackage

// File: rtl/adc_host_sync.sv
module adc_host_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[0] <= 1'b1;
          else        chain_q[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[i] <= 1'b1;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/adc_host_pacer.sv
module adc_host_pacer
  import adc_host_pkg::*;
#(
  parameter int RELINQ_CYC  = 4,
  parameter int CS_HIGH_CYC = 4,
  parameter int PERIOD_CYC  = 741
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic take,
  output logic pace_ok
);
  localparam int GAP = max2(RELINQ_CYC, CS_HIGH_CYC);
  localparam int GW  = $clog2(GAP + 1);
  localparam int PW  = $clog2(PERIOD_CYC + 1);

  logic [GW-1:0] gap_q;
  logic [PW-1:0] per_q;

  // Cycles chip-select has been high since its last rise.
  always_ff @(posedge clk) begin
    if (!rst_n)                 gap_q <= GW'(GAP);
    else if (!cs_n)             gap_q <= '0;
    else if (int'(gap_q) < GAP) gap_q <= gap_q + 1'b1;
  end

  // Cycles since the last accepted start.
  always_ff @(posedge clk) begin
    if (!rst_n)                        per_q <= PW'(PERIOD_CYC);
    else if (take)                     per_q <= PW'(1);
    else if (int'(per_q) < PERIOD_CYC) per_q <= per_q + 1'b1;
  end

  assign pace_ok = (int'(gap_q) >= GAP) && (int'(per_q) >= PERIOD_CYC);

  // R8: a start is taken only once both gaps are over (gap counter is fed by cs_n).
  assert_gap_before_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> cs_n && (int'(gap_q) >= GAP));
endmodule

// File: rtl/adc_host_fsm.sv
module adc_host_fsm
  import adc_host_pkg::*;
#(
  parameter int CS_LOW_CYC  = 4,
  parameter int CS_HIGH_CYC = 4,
  parameter int DATA_DLY_CYC = 4,
  parameter int ACQ_CYC     = 200,
  parameter int SETTLE_CYC  = 1200000,
  parameter int TIMEOUT_CYC = 600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic mode_in,
  input  logic pace_ok,
  input  logic hold,
  input  logic eoc_low,
  output logic cs_n,
  output logic rc,
  output logic hben,
  output logic cap_hi,
  output logic cap_lo,
  output logic take,
  output logic idle,
  output logic err_timeout
);
  localparam int W_FAST = max2(CS_HIGH_CYC, ACQ_CYC);
  localparam int W_SLOW = max2(W_FAST, SETTLE_CYC);
  localparam int L_RDLO = max2(DATA_DLY_CYC, CS_LOW_CYC);
  localparam int LMAX   = max2(max2(W_SLOW, TIMEOUT_CYC), max2(L_RDLO, CS_LOW_CYC));
  localparam int CW     = $clog2(LMAX + 1);

  seq_state_t    state_q, state_nxt;
  logic [CW-1:0] cnt_q;
  logic          mode_q, prev_shdn_q, settle_q, err_q;
  logic          conv_done, conv_tmo;
  pins_t         pins_q;

  assign idle = (state_q == S_IDLE);
  assign take = idle && start && pace_ok && !hold;

  always_comb begin
    state_nxt = state_q;
    cap_hi    = 1'b0;
    cap_lo    = 1'b0;
    conv_done = 1'b0;
    conv_tmo  = 1'b0;
    case (state_q)
      S_IDLE:   if (take) state_nxt = S_ACQ_LO;
      S_ACQ_LO: if (int'(cnt_q) == CS_LOW_CYC - 1) state_nxt = S_ACQ_HI;
      S_ACQ_HI: if (int'(cnt_q) == (settle_q ? W_SLOW : W_FAST) - 1) state_nxt = S_CNV_LO;
      S_CNV_LO: if (int'(cnt_q) == CS_LOW_CYC - 1) state_nxt = S_CNV_HI;
      S_CNV_HI: begin
        if (eoc_low && int'(cnt_q) >= CS_HIGH_CYC - 1) begin
          state_nxt = S_RD_HI;
          conv_done = 1'b1;
        end else if (int'(cnt_q) == TIMEOUT_CYC - 1) begin
          state_nxt = S_IDLE;
          conv_tmo  = 1'b1;
        end
      end
      S_RD_HI: if (int'(cnt_q) == DATA_DLY_CYC - 1) begin
        state_nxt = S_RD_LO;
        cap_hi    = 1'b1;
      end
      S_RD_LO: if (int'(cnt_q) == L_RDLO - 1) begin
        state_nxt = S_IDLE;
        cap_lo    = 1'b1;
      end
      default: state_nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_nxt;
      if (state_nxt != state_q)   cnt_q <= '0;
      else if (int'(cnt_q) < LMAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  // Cycle context: mode, settle need, power history, error flag.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q      <= 1'b0;
      settle_q    <= 1'b1;
      prev_shdn_q <= 1'b1;
      err_q       <= 1'b0;
    end else begin
      if (take) begin
        mode_q   <= mode_in;
        settle_q <= prev_shdn_q;
        err_q    <= 1'b0;
      end
      if (conv_done) prev_shdn_q <= mode_q;
      if (conv_tmo) begin
        prev_shdn_q <= 1'b1;
        err_q       <= 1'b1;
      end
    end
  end

  // Pins registered from the next state so the converter sees clean edges.
  always_ff @(posedge clk) begin
    if (!rst_n) pins_q <= pin_decode(S_IDLE, 1'b0);
    else        pins_q <= pin_decode(state_nxt, mode_q);
  end

  assign cs_n        = pins_q.cs_n;
  assign rc          = pins_q.rc;
  assign hben        = pins_q.hben;
  assign err_timeout = err_q;

  // Checker counters for pulse widths and fall spacing.
  logic [CW-1:0] low_run_q, high_run_q, since_fall_q;
  logic          cs_prev_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_run_q    <= '0;
      high_run_q   <= CW'(LMAX);
      since_fall_q <= CW'(LMAX);
      cs_prev_q    <= 1'b1;
    end else begin
      cs_prev_q <= cs_n;
      if (cs_n) begin
        low_run_q <= '0;
        if (int'(high_run_q) < LMAX) high_run_q <= high_run_q + 1'b1;
      end else begin
        high_run_q <= '0;
        if (int'(low_run_q) < LMAX) low_run_q <= low_run_q + 1'b1;
      end
      if (cs_prev_q && !cs_n)          since_fall_q <= CW'(1);
      else if (int'(since_fall_q) < LMAX) since_fall_q <= since_fall_q + 1'b1;
    end
  end

  assert_rc_moves_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rc != $past(rc)) |-> cs_n);

  assert_cs_low_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> int'(low_run_q) >= CS_LOW_CYC);

  assert_cs_high_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> int'(high_run_q) >= CS_HIGH_CYC);

  assert_settle_span_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cs_n) && state_q == S_CNV_LO && settle_q) |-> int'(since_fall_q) >= SETTLE_CYC);

  assert_timeout_parks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> cs_n && !rc && !hben);
endmodule

// File: rtl/adc_host_pack.sv
module adc_host_pack
  import adc_host_pkg::*;
#(
  parameter bit BIPOLAR = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_hi,
  input  logic             cap_lo,
  input  logic [BUS_W-1:0] bus,
  input  logic             ready,
  output logic             valid,
  output logic [RES_W-1:0] data,
  output logic [RES_W-1:0] sdata
);
  logic [HI_W-1:0]  hi_q;
  logic [RES_W-1:0] data_q;
  logic             valid_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q    <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      if (cap_hi) hi_q <= bus[HI_W-1:0];
      if (cap_lo) begin
        data_q  <= {hi_q, bus};
        valid_q <= 1'b1;
      end else if (valid_q && ready) begin
        valid_q <= 1'b0;
      end
    end
  end

  generate
    if (BIPOLAR) begin : g_bip
      assign sdata = {~data_q[RES_W-1], data_q[RES_W-2:0]};
    end else begin : g_uni
      assign sdata = data_q;
    end
  endgenerate

  assign valid = valid_q;
  assign data  = data_q;

  assert_hold_until_taken_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !ready) |=> valid_q && $stable(data_q));

  assert_upper_pad_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cap_hi |-> bus[BUS_W-1:HI_W] == '0);
endmodule

// File: rtl/adc_host_seq.sv
module adc_host_seq
  import adc_host_pkg::*;
#(
  parameter int CS_LOW_CYC   = 4,
  parameter int CS_HIGH_CYC  = 4,
  parameter int DATA_DLY_CYC = 4,
  parameter int ACQ_CYC      = 200,
  parameter int SETTLE_CYC   = 1200000,
  parameter int RELINQ_CYC   = 4,
  parameter int PERIOD_CYC   = 741,
  parameter int TIMEOUT_CYC  = 600,
  parameter int SYNC_STAGES  = 2,
  parameter bit BIPOLAR      = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             shutdown_sel,
  output logic             busy,
  output logic             err_timeout,
  output logic             adc_cs_n,
  output logic             adc_rc,
  output logic             adc_hben,
  input  logic             adc_eoc_n,
  input  logic [BUS_W-1:0] adc_data,
  output logic             sample_valid,
  input  logic             sample_ready,
  output logic [RES_W-1:0] sample_data,
  output logic [RES_W-1:0] sample_signed
);
  logic eoc_n_s, pace_ok, take, idle, cap_hi, cap_lo;

  adc_host_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(adc_eoc_n), .dout(eoc_n_s)
  );

  adc_host_pacer #(
    .RELINQ_CYC(RELINQ_CYC), .CS_HIGH_CYC(CS_HIGH_CYC), .PERIOD_CYC(PERIOD_CYC)
  ) u_pacer (
    .clk(clk), .rst_n(rst_n), .cs_n(adc_cs_n), .take(take), .pace_ok(pace_ok)
  );

  adc_host_fsm #(
    .CS_LOW_CYC(CS_LOW_CYC), .CS_HIGH_CYC(CS_HIGH_CYC), .DATA_DLY_CYC(DATA_DLY_CYC),
    .ACQ_CYC(ACQ_CYC), .SETTLE_CYC(SETTLE_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_in(shutdown_sel),
    .pace_ok(pace_ok), .hold(sample_valid), .eoc_low(!eoc_n_s),
    .cs_n(adc_cs_n), .rc(adc_rc), .hben(adc_hben),
    .cap_hi(cap_hi), .cap_lo(cap_lo), .take(take), .idle(idle),
    .err_timeout(err_timeout)
  );

  adc_host_pack #(.BIPOLAR(BIPOLAR)) u_pack (
    .clk(clk), .rst_n(rst_n), .cap_hi(cap_hi), .cap_lo(cap_lo), .bus(adc_data),
    .ready(sample_ready), .valid(sample_valid), .data(sample_data), .sdata(sample_signed)
  );

  assign busy = !(idle && pace_ok && !sample_valid);
endmodule

// File: tb/adc_host_seq_tb.sv
module adc_host_seq_tb;
  localparam int CSL = 2, CSH = 3, DLY = 2, ACQ = 4, SETTLE = 40;
  localparam int BR = 5, PERIOD = 35, TMO = 30;
  localparam int FAST_SPAN = CSL + ((CSH > ACQ) ? CSH : ACQ);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, shutdown_sel = 1'b0, sample_ready = 1'b1;
  logic busy, err_timeout, adc_cs_n, adc_rc, adc_hben, sample_valid;
  logic [13:0] sample_data, sample_signed;
  logic [7:0] adc_data;
  logic eoc_n_m;

  always #5 clk = ~clk;

  adc_host_seq #(
    .CS_LOW_CYC(CSL), .CS_HIGH_CYC(CSH), .DATA_DLY_CYC(DLY), .ACQ_CYC(ACQ),
    .SETTLE_CYC(SETTLE), .RELINQ_CYC(BR), .PERIOD_CYC(PERIOD), .TIMEOUT_CYC(TMO),
    .SYNC_STAGES(2), .BIPOLAR(1'b1)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .shutdown_sel(shutdown_sel),
    .busy(busy), .err_timeout(err_timeout), .adc_cs_n(adc_cs_n), .adc_rc(adc_rc),
    .adc_hben(adc_hben), .adc_eoc_n(eoc_n_m), .adc_data(adc_data),
    .sample_valid(sample_valid), .sample_ready(sample_ready),
    .sample_data(sample_data), .sample_signed(sample_signed)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // Converter model
  logic [13:0] res_code = 14'h0;
  int   conv_lat = 8;
  int   cyc = 0, phase, conv_cnt, f1, rise_t, last_ff, span, acq_count;
  logic prev_cs, drive_m, mode_m, conv_on, ref_on, need_m;
  int   v3, v5, v6, v7, v8;

  assign adc_data = (drive_m && !adc_cs_n) ? (adc_hben ? {2'b00, res_code[13:8]} : res_code[7:0])
                                           : 8'hEE;

  int low_run, high_run;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    prev_cs <= adc_cs_n;
    if (!rst_n) begin
      phase <= 0; conv_cnt <= 0; f1 <= 0; rise_t <= -100000; last_ff <= -100000;
      span <= 0; acq_count <= 0; drive_m <= 1'b0; mode_m <= 1'b0; conv_on <= 1'b0;
      ref_on <= 1'b0; need_m <= 1'b1; eoc_n_m <= 1'b1;
      v3 <= 0; v5 <= 0; v6 <= 0; v7 <= 0; v8 <= 0;
      low_run <= 0; high_run <= 1000; prev_cs <= 1'b1;
    end else begin
      if (adc_cs_n) begin high_run <= high_run + 1; low_run <= 0; end
      else begin low_run <= low_run + 1; high_run <= 0; end
      if (prev_cs && !adc_cs_n) begin
        if (high_run < CSH) v5 <= v5 + 1;
        if (phase == 0 || (phase == 2 && !adc_rc)) begin
          if (adc_rc) v3 <= v3 + 1;
          if (cyc - rise_t < BR || cyc - last_ff < PERIOD) v8 <= v8 + 1;
          last_ff <= cyc; f1 <= cyc; need_m <= !ref_on; phase <= 1;
          acq_count <= acq_count + 1; conv_on <= 1'b0;
        end else if (phase == 1) begin
          mode_m <= adc_rc; span <= cyc - f1;
          if (need_m && (cyc - f1) < SETTLE) v7 <= v7 + 1;
          conv_on <= 1'b1; conv_cnt <= 0; phase <= 2;
        end else begin
          if (eoc_n_m) v6 <= v6 + 1;
          drive_m <= 1'b1; phase <= 0;
        end
      end
      if (!prev_cs && adc_cs_n) begin
        if (low_run < CSL) v5 <= v5 + 1;
        if (drive_m) begin drive_m <= 1'b0; eoc_n_m <= 1'b1; rise_t <= cyc; end
      end
      if (conv_on) begin
        conv_cnt <= conv_cnt + 1;
        if (conv_lat != 0 && conv_cnt + 1 == conv_lat) begin
          eoc_n_m <= 1'b0; conv_on <= 1'b0; ref_on <= !mode_m;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_free();
    int n = 0;
    while (busy && n < 2000) begin @(negedge clk); n++; end
    if (busy) chk(1'b0, "R2", "busy never cleared", 1, 0);
  endtask

  task automatic pulse_start(input logic mode);
    shutdown_sel = mode;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_valid();
    int n = 0;
    while (!sample_valid && n < 3000) begin @(negedge clk); n++; end
  endtask

  logic exp_prev = 1'b1;

  task automatic run_one(input logic [13:0] code, input logic mode);
    wait_free();
    res_code = code;
    pulse_start(mode);
    wait_valid();
    chk(sample_valid == 1'b1, "R6", "sample_valid", sample_valid, 1);
    chk(sample_data == code, "R6", "sample_data", sample_data, code);
    chk(sample_signed == (code ^ 14'h2000), "R10", "sample_signed", sample_signed, code ^ 14'h2000);
    chk(mode_m == mode, "R4", "rc at second fall", mode_m, mode);
    chk(err_timeout == 1'b0, "R11", "err_timeout after good cycle", err_timeout, 0);
    if (exp_prev) chk(span >= SETTLE, "R7", "settled span", span, SETTLE);
    else          chk(span == FAST_SPAN, "R7", "fast span", span, FAST_SPAN);
    exp_prev = mode;
    @(negedge clk);
  endtask

  initial begin
    int runs;
    logic [13:0] held;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(adc_cs_n == 1'b1, "R1", "adc_cs_n", adc_cs_n, 1);
    chk(adc_rc == 1'b0, "R1", "adc_rc", adc_rc, 0);
    chk(adc_hben == 1'b0, "R1", "adc_hben", adc_hben, 0);
    chk(sample_valid == 1'b0, "R1", "sample_valid", sample_valid, 0);
    chk(err_timeout == 1'b0, "R1", "err_timeout", err_timeout, 0);
    chk(busy == 1'b0, "R1", "busy", busy, 0);

    runs = 0;
    run_one(14'h0000, 1'b0); runs++;
    run_one(14'h3FFF, 1'b0); runs++;
    run_one(14'h2000, 1'b1); runs++;
    run_one(14'h1FFF, 1'b0); runs++;
    for (int b = 0; b < 14; b++) begin
      run_one(14'(1) << b, (b % 3) == 0); runs++;
      run_one(~(14'(1) << b), (b % 4) == 1); runs++;
    end
    for (int i = 0; i < 64; i++) begin
      run_one(14'((i * 257 + i * i * 13) % 16384), (i % 5) == 2); runs++;
    end
    // R9: valid drops one cycle after handshake with ready high
    chk(sample_valid == 1'b0, "R9", "valid after handshake", sample_valid, 0);

    // R2: a second start during a running cycle is dropped
    wait_free();
    res_code = 14'h15A5;
    pulse_start(1'b0);
    repeat (3) @(negedge clk);
    chk(busy == 1'b1, "R2", "busy mid-cycle", busy, 1);
    pulse_start(1'b1);
    wait_valid();
    runs++;
    chk(sample_data == 14'h15A5, "R6", "data with extra start", sample_data, 14'h15A5);
    chk(mode_m == 1'b0, "R4", "mode not overwritten", mode_m, 0);
    exp_prev = 1'b0;
    @(negedge clk);
    repeat (60) @(negedge clk);
    chk(acq_count == runs, "R2", "acquisitions started", acq_count, runs);

    // R9 back-pressure: sample held, starts dropped, no chip-select activity
    sample_ready = 1'b0;
    run_one(14'h2C3D, 1'b0); runs++;
    held = sample_data;
    for (int k = 0; k < 40; k++) begin
      if (k == 10 || k == 25) begin start = 1'b1; shutdown_sel = 1'b1; end
      else start = 1'b0;
      @(negedge clk);
      if (k == 39 || k == 12 || k == 27) begin
        chk(sample_valid == 1'b1, "R9", "valid held", sample_valid, 1);
        chk(sample_data == held, "R9", "data held", sample_data, held);
        chk(adc_cs_n == 1'b1, "R2", "no cs while held", adc_cs_n, 1);
        chk(busy == 1'b1, "R2", "busy while held", busy, 1);
      end
    end
    start = 1'b0;
    chk(acq_count == runs, "R2", "no acquisition while held", acq_count, runs);
    sample_ready = 1'b1;
    @(negedge clk);
    chk(sample_valid == 1'b0, "R9", "valid after release", sample_valid, 0);

    // R11 timeout
    conv_lat = 0;
    wait_free();
    pulse_start(1'b0);
    begin
      int n = 0;
      while (!err_timeout && n < 500) begin @(negedge clk); n++; end
    end
    runs++;
    chk(err_timeout == 1'b1, "R11", "err_timeout", err_timeout, 1);
    chk(sample_valid == 1'b0, "R11", "no sample on timeout", sample_valid, 0);
    chk(adc_cs_n == 1'b1, "R11", "cs high after timeout", adc_cs_n, 1);
    repeat (5) @(negedge clk);
    chk(err_timeout == 1'b1, "R11", "err held", err_timeout, 1);
    conv_lat = 8;
    exp_prev = 1'b1;
    run_one(14'h1234, 1'b0); runs++;
    run_one(14'h0F0F, 1'b0); runs++;

    chk(v3 == 0, "R3", "rc high at first fall", v3, 0);
    chk(v5 == 0, "R5", "cs width violations", v5, 0);
    chk(v6 == 0, "R6", "read before end of conversion", v6, 0);
    chk(v7 == 0, "R7", "settle violations", v7, 0);
    chk(v8 == 0, "R8", "gap or period violations", v8, 0);
    chk(acq_count == runs, "R2", "total acquisitions", acq_count, runs);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule